// File: doc/BRIEF.md
# Dual-Halfword Multiply-Accumulate Unit

This execution unit sits beside a two-read-port register file. Each cycle it receives two 32-bit register operands, which carry one coefficient and one sample. It picks a signed 16-bit half out of each operand and multiplies the two halves. The product goes into an accumulator held inside the unit. The running sum never travels through the register file, so a multiply-accumulate needs only the two operand reads. One 32-bit word can hold two samples or two coefficients, and the half-select bits let consecutive operations take the two halves in turn.

A finish command ends a sequence. One cycle later the unit presents the saturated 32-bit sum on a single write port, together with the destination register index. The accumulator is 40 bits wide, so it carries 8 guard bits above the product width. Clamping to 32 bits happens only at writeback, which lets intermediate sums leave the 32-bit range and come back without loss.

A small controller tracks the sequence with three states:
- `ST_IDLE`: no sum is in progress.
- `ST_ACCUM`: a sequence is collecting products.
- `ST_WBACK`: the write port is valid.

The transitions are:
- finish, from any state, goes to `ST_WBACK`.
- `ST_IDLE` goes to `ST_ACCUM` on a MAC.
- `ST_ACCUM` stays in `ST_ACCUM` until finish.
- `ST_WBACK` goes to `ST_ACCUM` if a MAC arrives in the writeback cycle, and to `ST_IDLE` otherwise.

Top module: `dsp_mac_unit`

## Requirements
- R1: With `hi_sel_a`/`hi_sel_b` high, the operand half used is bits [31:16]; with the select low, bits [15:0] are used. Each half is sign-extended, and the product is the full signed 32-bit result of the 16x16 multiply.
- R2: A MAC is accepted on every cycle that `mac_valid` is high, with no stall between consecutive MACs. Each accepted MAC adds its product to the running sum.
- R3: `clear_acc` together with `mac_valid` loads the new product in place of the old sum. `clear_acc` without `mac_valid` sets the sum to zero.
- R4: The cycle after a cycle with `finish` high has `wb_valid` high, with `wb_addr` equal to `dest_idx` as sampled with finish. `wb_valid` is low in every cycle that does not follow a finish. The written value includes a MAC issued in the same cycle as finish.
- R5: After a finish the sum restarts from zero. A MAC issued during the `wb_valid` cycle starts the new sequence without adding the previous total.
- R6: The sum is held in 40 bits and is not clamped on each accumulate. An intermediate sum that exceeds the 32-bit range and later returns into it is written back exactly.
- R7: At writeback, a sum above 2^31-1 is written as 32'h7FFFFFFF and a sum below -2^31 is written as 32'h80000000.
- R8: `sat_sticky` is set by a writeback that clamps. It stays set across later non-clamping writebacks and is cleared only by `clear_acc`.
- R9: After reset, `wb_valid`, `wb_addr`, `wb_data` and `sat_sticky` are zero, and the sum is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_valid | input | 1 | Issue one multiply-accumulate this cycle |
| clear_acc | input | 1 | Restart the sum; clears the sticky flag |
| hi_sel_a | input | 1 | Take upper half of `opnd_a` when high |
| hi_sel_b | input | 1 | Take upper half of `opnd_b` when high |
| opnd_a | input | 32 | First register operand (coefficient) |
| opnd_b | input | 32 | Second register operand (sample) |
| finish | input | 1 | End the sequence and request writeback |
| dest_idx | input | 5 | Destination register index for the writeback |
| wb_valid | output | 1 | Write port valid, one cycle |
| wb_addr | output | 5 | Destination register index |
| wb_data | output | 32 | Saturated sum |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
The assertions check the writeback timing on every cycle: a valid pulse follows each finish and never appears otherwise, and the address is the index that came with the finish. They also check that the sticky flag rises only on a writeback that carries a clamp value, holds until a clear, and falls after a clear. The arithmetic can only be shown by the bench's scenarios, which compare every cycle against an integer reference sum. These scenarios cover half selection, back-to-back accumulation, load-on-clear, restart in the writeback cycle, a guard-bit excursion that returns into range, and clamping in both directions.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_WBACK = 2'd2
    } dmac_state_e;

endpackage

// File: rtl/dmac_opsel.sv
module dmac_opsel #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0]       word,
    input  logic                      take_hi,
    output logic signed [HALF_W-1:0]  half
);
    always_comb begin
        if (take_hi) begin
            half = word[2*HALF_W-1:HALF_W];
        end else begin
            half = word[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/dmac_mult.sv
module dmac_mult #(
    parameter int HALF_W = 16
) (
    input  logic signed [HALF_W-1:0]   mul_x,
    input  logic signed [HALF_W-1:0]   mul_y,
    output logic signed [2*HALF_W-1:0] mul_p
);
    always_comb begin
        mul_p = mul_x * mul_y;
    end
endmodule

// File: rtl/dmac_sat.sv
module dmac_sat #(
    parameter int IN_W  = 40,
    parameter int OUT_W = 32
) (
    input  logic signed [IN_W-1:0] sum_in,
    output logic [OUT_W-1:0]       sat_out,
    output logic                   clamped
);
    localparam int TOP_W = IN_W - OUT_W + 1;

    logic [TOP_W-1:0] top_bits;

    always_comb begin
        top_bits = sum_in[IN_W-1:OUT_W-1];
        clamped  = !((top_bits == '0) || (top_bits == '1));
        if (!clamped) begin
            sat_out = sum_in[OUT_W-1:0];
        end else if (sum_in[IN_W-1]) begin
            sat_out = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            sat_out = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mac_go,
    input  logic        fin_go,
    output dmac_state_e cur_state,
    output logic        wb_fire
);
    dmac_state_e nxt_state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_state <= ST_IDLE;
        end else begin
            cur_state <= nxt_state;
        end
    end

    always_comb begin
        nxt_state = cur_state;
        if (fin_go) begin
            nxt_state = ST_WBACK;
        end else begin
            unique case (cur_state)
                ST_IDLE:  nxt_state = mac_go ? ST_ACCUM : ST_IDLE;
                ST_ACCUM: nxt_state = ST_ACCUM;
                ST_WBACK: nxt_state = mac_go ? ST_ACCUM : ST_IDLE;
                default:  nxt_state = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wb_fire = (cur_state == ST_WBACK);
    end
endmodule

// File: rtl/dsp_mac_unit.sv
module dsp_mac_unit
    import dmac_pkg::*;
#(
    parameter int HALF_W  = 16,
    parameter int GUARD_W = 8,
    parameter int REG_AW  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mac_valid,
    input  logic                   clear_acc,
    input  logic                   hi_sel_a,
    input  logic                   hi_sel_b,
    input  logic [2*HALF_W-1:0]    opnd_a,
    input  logic [2*HALF_W-1:0]    opnd_b,
    input  logic                   finish,
    input  logic [REG_AW-1:0]      dest_idx,
    output logic                   wb_valid,
    output logic [REG_AW-1:0]      wb_addr,
    output logic [2*HALF_W-1:0]    wb_data,
    output logic                   sat_sticky
);
    localparam int DATA_W = 2 * HALF_W;
    localparam int PROD_W = 2 * HALF_W;
    localparam int ACC_W  = PROD_W + GUARD_W;
    localparam int N_OPND = 2;

    logic [N_OPND-1:0][DATA_W-1:0] opnd_word;
    logic [N_OPND-1:0]             opnd_hi;
    logic signed [HALF_W-1:0]      opnd_half [N_OPND];

    logic signed [PROD_W-1:0]      product;
    logic signed [ACC_W-1:0]       product_ext;
    logic signed [ACC_W-1:0]       acc_q;
    logic signed [ACC_W-1:0]       acc_next;
    logic [DATA_W-1:0]             sat_val;
    logic                          sat_hit;
    dmac_state_e                   seq_state;

    assign opnd_word[0] = opnd_a;
    assign opnd_word[1] = opnd_b;
    assign opnd_hi[0]   = hi_sel_a;
    assign opnd_hi[1]   = hi_sel_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_sel
        dmac_opsel #(.HALF_W(HALF_W)) u_sel (
            .word    (opnd_word[g]),
            .take_hi (opnd_hi[g]),
            .half    (opnd_half[g])
        );
    end

    dmac_mult #(.HALF_W(HALF_W)) u_mult (
        .mul_x (opnd_half[0]),
        .mul_y (opnd_half[1]),
        .mul_p (product)
    );

    assign product_ext = {{GUARD_W{product[PROD_W-1]}}, product};

    // Sum seen by this cycle's finish: includes a MAC issued alongside it.
    always_comb begin
        if (clear_acc) begin
            acc_next = mac_valid ? product_ext : '0;
        end else if (mac_valid) begin
            acc_next = acc_q + product_ext;
        end else begin
            acc_next = acc_q;
        end
    end

    dmac_sat #(.IN_W(ACC_W), .OUT_W(DATA_W)) u_sat (
        .sum_in  (acc_next),
        .sat_out (sat_val),
        .clamped (sat_hit)
    );

    dmac_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mac_go    (mac_valid),
        .fin_go    (finish),
        .cur_state (seq_state),
        .wb_fire   (wb_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (finish) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_addr <= '0;
            wb_data <= '0;
        end else if (finish) begin
            wb_addr <= dest_idx;
            wb_data <= sat_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_sticky <= 1'b0;
        end else begin
            sat_sticky <= (sat_sticky & ~clear_acc) | (finish & sat_hit);
        end
    end

    logic unused_state;
    assign unused_state = ^seq_state;
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_acc,
    input logic              finish,
    input logic [REG_AW-1:0] dest_idx,
    input logic              wb_valid,
    input logic [REG_AW-1:0] wb_addr,
    input logic [DATA_W-1:0] wb_data,
    input logic              sat_sticky
);
    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

    // R4
    wb_after_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> wb_valid);

    // R4
    wb_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> !wb_valid);

    // R4
    wb_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (wb_addr == $past(dest_idx)));

    // R8
    sticky_rise_on_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_sticky) |-> wb_valid);

    // R7
    clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_sticky) |-> (wb_data == POS_MAX || wb_data == NEG_MAX));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_sticky && !clear_acc) |=> sat_sticky);

    // R8
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_acc && !finish) |=> !sat_sticky);
endmodule

bind dsp_mac_unit dmac_chk #(.DATA_W(2*HALF_W), .REG_AW(REG_AW)) u_dmac_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_acc  (clear_acc),
    .finish     (finish),
    .dest_idx   (dest_idx),
    .wb_valid   (wb_valid),
    .wb_addr    (wb_addr),
    .wb_data    (wb_data),
    .sat_sticky (sat_sticky)
);

// File: tb/dsp_mac_unit_test.sv
`timescale 1ns/1ps
module dsp_mac_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mac_valid = 1'b0, clear_acc = 1'b0, hi_sel_a = 1'b0, hi_sel_b = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        finish = 1'b0;
    logic [4:0]  dest_idx = '0;
    logic        wb_valid;
    logic [4:0]  wb_addr;
    logic [31:0] wb_data;
    logic        sat_sticky;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    string cur_req = "R9";
    bit done = 1'b0;

    // reference state
    longint ref_sum = 0;
    bit     ref_wv = 0, ref_flag = 0;
    logic [4:0]  ref_addr = '0;
    logic [31:0] ref_data = '0;

    always #5 clk = ~clk;

    dsp_mac_unit uut (.*);

    function automatic longint pick(input logic [31:0] w, input logic hi);
        int v;
        v = hi ? int'(w) >>> 16 : int'({{16{w[15]}}, w[15:0]});
        return longint'(v);
    endfunction

    always @(posedge clk) begin
        longint nxt, prod;
        if (!rst_n) begin
            ref_sum = 0; ref_wv = 0; ref_flag = 0; ref_addr = '0; ref_data = '0;
        end else begin
            prod = pick(opnd_a, hi_sel_a) * pick(opnd_b, hi_sel_b);
            if (clear_acc) nxt = mac_valid ? prod : 0;
            else if (mac_valid) nxt = ref_sum + prod;
            else nxt = ref_sum;
            if (clear_acc) ref_flag = 0;
            if (finish) begin
                ref_wv = 1; ref_addr = dest_idx;
                if (nxt > 64'sd2147483647) begin ref_data = 32'h7FFFFFFF; ref_flag = 1; end
                else if (nxt < -64'sd2147483648) begin ref_data = 32'h80000000; ref_flag = 1; end
                else ref_data = nxt[31:0];
                ref_sum = 0;
            end else begin
                ref_wv = 0; ref_sum = nxt;
            end
        end
    end

    task automatic compare(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cycles++;
            compare(cur_req, "wb_valid", longint'(wb_valid), longint'(ref_wv));
            compare(cur_req, "sat_sticky", longint'(sat_sticky), longint'(ref_flag));
            if (ref_wv) begin
                compare(cur_req, "wb_addr", longint'(wb_addr), longint'(ref_addr));
                compare(cur_req, "wb_data", longint'(wb_data), longint'(ref_data));
            end
        end
    end

    task automatic idle_in();
        mac_valid = 0; clear_acc = 0; finish = 0; hi_sel_a = 0; hi_sel_b = 0;
    endtask

    task automatic op(input bit m, input bit c, input bit ha, input bit hb,
                      input logic [31:0] a, input logic [31:0] b,
                      input bit f, input logic [4:0] d);
        mac_valid = m; clear_acc = c; hi_sel_a = ha; hi_sel_b = hb;
        opnd_a = a; opnd_b = b; finish = f; dest_idx = d;
        @(negedge clk);
        idle_in();
    endtask

    task automatic gap();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #100000000;
        n_bad++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values at the ports
        compare("R9", "wb_valid", longint'(wb_valid), 0);
        compare("R9", "wb_addr", longint'(wb_addr), 0);
        compare("R9", "wb_data", longint'(wb_data), 0);
        compare("R9", "sat_sticky", longint'(sat_sticky), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: sum starts at zero
        op(0, 0, 0, 0, 0, 0, 1, 5'd1); gap();

        // R1: all four half combinations (hi=3/lo=-2 ; hi=-32768/lo=5)
        cur_req = "R1";
        op(1, 0, 0, 0, 32'h0003_FFFE, 32'h8000_0005, 0, 0);
        op(1, 0, 1, 0, 32'h0003_FFFE, 32'h8000_0005, 0, 0);
        op(1, 0, 0, 1, 32'h0003_FFFE, 32'h8000_0005, 0, 0);
        op(1, 0, 1, 1, 32'h0003_FFFE, 32'h8000_0005, 1, 5'd7); gap();

        // R2: back-to-back MACs, last one issued with finish
        cur_req = "R2";
        for (int i = 0; i < 6; i++)
            op(1, 0, i[0], ~i[0], 32'h1234_F00D + i, 32'hFFF0_0777 - i, i == 5, 5'd12);
        gap();

        // R3: clear with MAC loads product; clear alone zeroes
        cur_req = "R3";
        op(1, 0, 0, 0, 32'd1000, 32'd1000, 0, 0);
        op(1, 1, 0, 0, 32'd7, 32'd9, 0, 0);
        op(0, 0, 0, 0, 0, 0, 1, 5'd3); gap();
        op(1, 0, 0, 0, 32'd500, 32'd500, 0, 0);
        op(0, 1, 0, 0, 0, 0, 0, 0);
        op(1, 0, 0, 0, 32'd2, 32'd3, 1, 5'd4); gap();

        // R4: finish without MAC, varied addresses, finish on consecutive cycles
        cur_req = "R4";
        op(1, 0, 0, 0, 32'd11, 32'd13, 0, 0);
        op(0, 0, 0, 0, 0, 0, 1, 5'd31);
        op(0, 0, 0, 0, 0, 0, 1, 5'd16); gap();

        // R5: MAC in the writeback cycle starts fresh
        cur_req = "R5";
        op(1, 0, 0, 0, 32'd100, 32'd100, 1, 5'd8);
        op(1, 0, 0, 0, 32'd3, 32'd4, 0, 0);
        op(1, 0, 0, 0, 32'd5, 32'd6, 1, 5'd9); gap();

        // R6: 3 x 2^30 then 2 x (-32768*32767) -> 1073807360, no clamp
        cur_req = "R6";
        for (int i = 0; i < 3; i++) op(1, 0, 0, 0, 32'h0000_8000, 32'h0000_8000, 0, 0);
        op(1, 0, 0, 0, 32'h0000_8000, 32'h0000_7FFF, 0, 0);
        op(1, 0, 0, 0, 32'h0000_8000, 32'h0000_7FFF, 1, 5'd10); gap();
        compare("R6", "wb_data exact", longint'(wb_data), 64'd1073807360);

        // R7: positive clamp, then negative clamp
        cur_req = "R7";
        for (int i = 0; i < 3; i++) op(1, 0, 1, 1, 32'h8000_0000, 32'h8000_0000, i == 2, 5'd20);
        gap();
        for (int i = 0; i < 3; i++) op(1, 0, 0, 1, 32'h0000_8000, 32'h7FFF_0000, i == 2, 5'd21);
        gap();

        // R8: flag holds through a normal writeback, cleared by clear_acc
        cur_req = "R8";
        op(1, 0, 0, 0, 32'd2, 32'd2, 1, 5'd22); gap();
        compare("R8", "sticky held", longint'(sat_sticky), 1);
        op(0, 1, 0, 0, 0, 0, 0, 0); gap();
        compare("R8", "sticky cleared", longint'(sat_sticky), 0);
        op(1, 0, 0, 0, 32'd2, 32'd2, 1, 5'd23); gap();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule